// File: doc/BRIEF.md
# BCD Calendar Clock with Seven-Segment Display

This block keeps the time of day and the calendar date as packed BCD digits and drives an eight-digit seven-segment display. A one-pulse-per-second input advances the seconds. The seconds carry into the minutes, the minutes into the hours, and the hours into the day. The day carries into the month and the month into the year. The limit for each month comes from the month number and from a leap-year test on the BCD year digits. The block reports that leap-year result on its own output.

Software or front-panel logic sets any field through a 3-bit field code, a load strobe and a pair of BCD digits. The display shows the date for four seconds, then the time for four seconds, and repeats. All state sits in one clock domain with a synchronous reset.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the calendar holds year 2000, month 01, day 01, time 00:00:00, the display shows the date view, and `leap_year` is 1.
- R2: Each rising edge of `sec_tick` gives exactly one one-second advance. This holds however many system clock cycles the tick stays high.
- R3: Seconds count 00 to 59, and so do minutes. When seconds pass 59 they return to 00 and the minutes advance. When minutes pass 59 they return to 00 and the hours advance.
- R4: Hours count 00 to 23. One second after 23:59:59 the time reads 00:00:00 and the day has advanced by one.
- R5: April, June, September and November end after day 30. January, March, May, July, August, October and December end after day 31. Leaving the last day sets the day to 01 and advances the month.
- R6: February ends after day 29 when `leap_year` is 1 and after day 28 when it is 0.
- R7: `leap_year` is 1 when the year is divisible by 4 and does not end in 00. For a year ending in 00 it is 1 only when the upper two digits are divisible by 4. So 2000, 2400 and 0000 are leap years, and 1900 and 2100 are not.
- R8: Leaving month 12 sets the month to 01 and advances the year. The year 9999 advances to 0000.
- R9: While `load` is high, the field chosen by `field_sel` takes the value {`digit_hi`,`digit_lo`} on each clock. The codes are: 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 lower two year digits, 6 upper two year digits. Code 7 changes nothing.
- R10: A tick pulse that arrives while `load` is high advances no field. Counting resumes from the loaded value on the next tick after `load` falls.
- R11: Each digit drives 7 active-high bits ordered a (bit 6) down to g (bit 0). The patterns for 0 to 9 are 1111110, 0110000, 1101101, 1111001, 0110011, 1011011, 1011111, 1110000, 1111111 and 1111011. The code F shows only segment g (0000001). Any other value above 9 shows the pattern for 0.
- R12: `seg_out[7*i+6 : 7*i]` drives digit i, where digit 7 is the leftmost. In the date view, digits 7 to 0 show the four year digits, then the two month digits, then the two day digits.
- R13: In the time view, digits 7 to 0 show the two hour digits, a dash, the two minute digits, a dash, and the two second digits.
- R14: The view changes after every fourth tick pulse, counted from reset. Pulses that arrive during a load also count. The date view comes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-pulse-per-second input; only its rising edge counts |
| field_sel | input | 3 | Field code for loading |
| load | input | 1 | Load strobe; also suspends counting |
| digit_hi | input | 4 | Upper BCD digit of the load value |
| digit_lo | input | 4 | Lower BCD digit of the load value |
| seg_out | output | 56 | Eight 7-bit segment patterns, digit 7 in the top bits |
| leap_year | output | 1 | The current year is a leap year |

## Verification
A rising `sec_tick` is detected on the first clock edge that sees it high. Every counter takes its new value on that same edge. The segment outputs and `leap_year` are combinational from the registers, so each result appears one edge after the stimulus. A load likewise appears one edge after the strobe. The bench drives inputs on the falling edge. It samples on the falling edge after the edge that takes the change, and it lowers the tick before sampling so that a held tick cannot hide a second advance. For each check the bench works out which view should be showing from its own count of tick pulses, and places every rollover so that the result lands in the view it needs to observe.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int NUM_DIGITS = 8;
  localparam int SEG_BITS   = 7;
  localparam int NUM_FIELDS = 7;

  localparam logic [3:0] SEP_CODE = 4'hF;

  typedef struct packed {
    logic [7:0] hr;
    logic [7:0] mn;
    logic [7:0] sc;
  } tod_t;

  typedef struct packed {
    logic [15:0] yr;
    logic [7:0]  mo;
    logic [7:0]  dy;
  } date_t;

  // advance a two-digit BCD value by one (no range wrap)
  function automatic logic [7:0] bcd2_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // advance a four-digit BCD value by one, 9999 -> 0000
  function automatic logic [15:0] bcd4_inc(input logic [15:0] v);
    if (v == 16'h9999) return 16'h0000;
    if (v[7:0] == 8'h99) return {bcd2_inc(v[15:8]), 8'h00};
    return {v[15:8], bcd2_inc(v[7:0])};
  endfunction

  // 10*t + u is divisible by 4 exactly when 2*t + u is
  function automatic logic pair_div4(input logic [7:0] v);
    logic [3:0] u;
    u = v[3:0];
    if (v[4]) return (u == 4'd2) || (u == 4'd6);
    return (u == 4'd0) || (u == 4'd4) || (u == 4'd8);
  endfunction

  function automatic logic year_is_leap(input logic [15:0] yr);
    if (yr[7:0] == 8'h00) return pair_div4(yr[15:8]);
    return pair_div4(yr[7:0]);
  endfunction

  // 2-bit length code: 0 -> 28, 1 -> 29, 2 -> 30, 3 -> 31
  function automatic logic [1:0] month_code(input logic [7:0] mo, input logic leap);
    case (mo)
      8'h02:                      return leap ? 2'd1 : 2'd0;
      8'h04, 8'h06, 8'h09, 8'h11: return 2'd2;
      default:                    return 2'd3;
    endcase
  endfunction

  function automatic logic [7:0] last_day(input logic [1:0] code);
    case (code)
      2'd0:    return 8'h28;
      2'd1:    return 8'h29;
      2'd2:    return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

  // active-high, bit 6 = a ... bit 0 = g
  function automatic logic [6:0] seg7(input logic [3:0] n);
    case (n)
      4'd1:    return 7'b0110000;
      4'd2:    return 7'b1101101;
      4'd3:    return 7'b1111001;
      4'd4:    return 7'b0110011;
      4'd5:    return 7'b1011011;
      4'd6:    return 7'b1011111;
      4'd7:    return 7'b1110000;
      4'd8:    return 7'b1111111;
      4'd9:    return 7'b1111011;
      SEP_CODE: return 7'b0000001;
      default: return 7'b1111110;
    endcase
  endfunction

endpackage

// File: rtl/cal_tick_edge.sv
module cal_tick_edge (
  input  logic clk,
  input  logic rst,
  input  logic tick_in,
  output logic pulse
);
  logic tick_q;

  always_ff @(posedge clk) begin
    if (rst) tick_q <= 1'b0;
    else     tick_q <= tick_in;
  end

  assign pulse = tick_in & ~tick_q;
endmodule

// File: rtl/cal_time_counter.sv
module cal_time_counter
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  logic       load,
  input  logic [2:0] sel_oh,
  input  logic [7:0] load_val,
  output tod_t       tod,
  output logic       day_step
);
  logic step_en, sec_wrap, min_wrap;

  assign step_en  = step & ~load;
  assign sec_wrap = step_en  && (tod.sc >= 8'h59);
  assign min_wrap = sec_wrap && (tod.mn >= 8'h59);
  assign day_step = min_wrap && (tod.hr >= 8'h23);

  always_ff @(posedge clk) begin
    if (rst) begin
      tod <= '0;
    end else if (load) begin
      if (sel_oh[0]) tod.sc <= load_val;
      if (sel_oh[1]) tod.mn <= load_val;
      if (sel_oh[2]) tod.hr <= load_val;
    end else if (step_en) begin
      tod.sc <= sec_wrap ? 8'h00 : bcd2_inc(tod.sc);
      if (sec_wrap) tod.mn <= min_wrap ? 8'h00 : bcd2_inc(tod.mn);
      if (min_wrap) tod.hr <= day_step ? 8'h00 : bcd2_inc(tod.hr);
    end
  end
endmodule

// File: rtl/cal_date_counter.sv
module cal_date_counter
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  logic       load,
  input  logic [3:0] sel_oh,
  input  logic [7:0] load_val,
  output date_t      date,
  output logic       leap,
  output logic       day_wrap,
  output logic       month_wrap
);
  logic [7:0] limit;

  assign leap       = year_is_leap(date.yr);
  assign limit      = last_day(month_code(date.mo, leap));
  assign day_wrap   = step && (date.dy >= limit);
  assign month_wrap = day_wrap && (date.mo >= 8'h12);

  always_ff @(posedge clk) begin
    if (rst) begin
      date.yr <= 16'h2000;
      date.mo <= 8'h01;
      date.dy <= 8'h01;
    end else if (load) begin
      if (sel_oh[0]) date.dy       <= load_val;
      if (sel_oh[1]) date.mo       <= load_val;
      if (sel_oh[2]) date.yr[7:0]  <= load_val;
      if (sel_oh[3]) date.yr[15:8] <= load_val;
    end else if (step) begin
      date.dy <= day_wrap ? 8'h01 : bcd2_inc(date.dy);
      if (day_wrap)   date.mo <= month_wrap ? 8'h01 : bcd2_inc(date.mo);
      if (month_wrap) date.yr <= bcd4_inc(date.yr);
    end
  end
endmodule

// File: rtl/cal_display.sv
module cal_display
  import cal_pkg::*;
#(
  parameter int VIEW_SECS = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           step,
  input  tod_t                           tod,
  input  date_t                          date,
  output logic                           show_time,
  output logic [NUM_DIGITS*SEG_BITS-1:0] seg
);
  localparam int CW = (VIEW_SECS > 1) ? $clog2(VIEW_SECS) : 1;
  localparam logic [CW-1:0] LAST = CW'(VIEW_SECS - 1);

  logic [CW-1:0]           cnt;
  logic [NUM_DIGITS*4-1:0] word;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      show_time <= 1'b0;
    end else if (step) begin
      if (cnt == LAST) begin
        cnt       <= '0;
        show_time <= ~show_time;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign word = show_time ? {tod.hr, SEP_CODE, tod.mn, SEP_CODE, tod.sc} : date;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    assign seg[i*SEG_BITS +: SEG_BITS] = seg7(word[i*4 +: 4]);
  end
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
  import cal_pkg::*;
#(
  parameter int VIEW_SECS = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sec_tick,
  input  logic [2:0]  field_sel,
  input  logic        load,
  input  logic [3:0]  digit_hi,
  input  logic [3:0]  digit_lo,
  output logic [55:0] seg_out,
  output logic        leap_year
);
  logic [NUM_FIELDS-1:0] sel_oh;
  logic [7:0]            load_val;
  logic                  sec_pulse, day_step, day_wrap, month_wrap, show_time;
  tod_t                  tod;
  date_t                 date;

  assign load_val = {digit_hi, digit_lo};

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_sel
    assign sel_oh[i] = load && (field_sel == 3'(i));
  end

  cal_tick_edge u_tick (
    .clk(clk), .rst(rst), .tick_in(sec_tick), .pulse(sec_pulse)
  );

  cal_time_counter u_time (
    .clk(clk), .rst(rst), .step(sec_pulse), .load(load),
    .sel_oh(sel_oh[2:0]), .load_val(load_val), .tod(tod), .day_step(day_step)
  );

  cal_date_counter u_date (
    .clk(clk), .rst(rst), .step(day_step), .load(load),
    .sel_oh(sel_oh[6:3]), .load_val(load_val), .date(date),
    .leap(leap_year), .day_wrap(day_wrap), .month_wrap(month_wrap)
  );

  cal_display #(.VIEW_SECS(VIEW_SECS)) u_disp (
    .clk(clk), .rst(rst), .step(sec_pulse), .tod(tod), .date(date),
    .show_time(show_time), .seg(seg_out)
  );
endmodule

// File: rtl/cal_checker.sv
module cal_checker
  import cal_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       sec_pulse,
  input logic       load,
  input logic [6:0] sel_oh,
  input logic [7:0] load_val,
  input tod_t       tod,
  input date_t      date,
  input logic       day_step,
  input logic       day_wrap,
  input logic       month_wrap,
  input logic       show_time
);
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    sec_pulse |=> !sec_pulse);

  a_r3_sec_wrap: assert property (@(posedge clk) disable iff (rst)
    sec_pulse && !load && tod.sc == 8'h59 |=> tod.sc == 8'h00);

  a_r3_min_carry: assert property (@(posedge clk) disable iff (rst)
    sec_pulse && !load && tod.sc == 8'h59 && tod.mn == 8'h59 |=> tod.mn == 8'h00);

  a_r4_midnight: assert property (@(posedge clk) disable iff (rst)
    day_step |=> tod == '0);

  a_r5_day_restart: assert property (@(posedge clk) disable iff (rst)
    day_wrap |=> date.dy == 8'h01);

  a_r8_month_restart: assert property (@(posedge clk) disable iff (rst)
    month_wrap |=> date.mo == 8'h01);

  a_r9_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_oh));

  a_r9_load_seconds: assert property (@(posedge clk) disable iff (rst)
    load && sel_oh[0] |=> tod.sc == $past(load_val));

  a_r10_load_freezes: assert property (@(posedge clk) disable iff (rst)
    load && !sel_oh[0] |=> $stable(tod.sc));

  a_r10_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !sec_pulse && !load |=> $stable(tod) && $stable(date));

  a_r14_view_on_pulse: assert property (@(posedge clk) disable iff (rst)
    !sec_pulse |=> $stable(show_time));
endmodule

bind bcd_calendar_clock cal_checker u_chk (
  .clk(clk), .rst(rst), .sec_pulse(sec_pulse), .load(load), .sel_oh(sel_oh),
  .load_val(load_val), .tod(tod), .date(date), .day_step(day_step),
  .day_wrap(day_wrap), .month_wrap(month_wrap), .show_time(show_time)
);

// File: tb/bcd_calendar_clock_test.sv
module bcd_calendar_clock_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sec_tick = 1'b0;
  logic [2:0]  field_sel = 3'd7;
  logic        load = 1'b0;
  logic [3:0]  digit_hi = 4'd0;
  logic [3:0]  digit_lo = 4'd0;
  logic [55:0] seg_out;
  logic        leap_year;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model, plain integers
  int m_s = 0, m_m = 0, m_h = 0, m_d = 1, m_mo = 1, m_y = 2000;
  int pulses = 0;

  bcd_calendar_clock uut (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .field_sel(field_sel),
    .load(load), .digit_hi(digit_hi), .digit_lo(digit_lo),
    .seg_out(seg_out), .leap_year(leap_year)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit ref_leap(int y);
    return ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
  endfunction

  function automatic int ref_dim(int mo, int y);
    if (mo == 2) return ref_leap(y) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [6:0] ref_seg(int d);
    case (d)
      0: return 7'h7E;  1: return 7'h30;  2: return 7'h6D;  3: return 7'h79;
      4: return 7'h33;  5: return 7'h5B;  6: return 7'h5F;  7: return 7'h70;
      8: return 7'h7F;  9: return 7'h7B;  15: return 7'h01;
      default: return 7'h7E;
    endcase
  endfunction

  function automatic bit view_is_time();
    return ((pulses / 4) % 2) == 1;
  endfunction

  function automatic logic [55:0] ref_display();
    int n[8];
    logic [55:0] v;
    if (view_is_time()) begin
      n[7] = m_h / 10; n[6] = m_h % 10; n[5] = 15;
      n[4] = m_m / 10; n[3] = m_m % 10; n[2] = 15;
      n[1] = m_s / 10; n[0] = m_s % 10;
    end else begin
      n[7] = m_y / 1000; n[6] = (m_y / 100) % 10;
      n[5] = (m_y / 10) % 10; n[4] = m_y % 10;
      n[3] = m_mo / 10; n[2] = m_mo % 10;
      n[1] = m_d / 10; n[0] = m_d % 10;
    end
    for (int i = 0; i < 8; i++) v[i*7 +: 7] = ref_seg(n[i]);
    return v;
  endfunction

  task automatic check_vec(string req, logic [55:0] act, logic [55:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: seg_out actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    check_vec(req, seg_out, ref_display());
    check_bit({req, " leap"}, leap_year, ref_leap(m_y));
  endtask

  task automatic model_step();
    m_s++;
    if (m_s == 60) begin
      m_s = 0; m_m++;
      if (m_m == 60) begin
        m_m = 0; m_h++;
        if (m_h == 24) begin
          m_h = 0; m_d++;
          if (m_d > ref_dim(m_mo, m_y)) begin
            m_d = 1; m_mo++;
            if (m_mo > 12) begin
              m_mo = 1; m_y = (m_y + 1) % 10000;
            end
          end
        end
      end
    end
  endtask

  task automatic tick(int hold = 1);
    @(negedge clk); sec_tick = 1'b1;
    repeat (hold) @(negedge clk);
    sec_tick = 1'b0;
    @(negedge clk);
    pulses++;
    model_step();
  endtask

  task automatic model_load(int sel, int val);
    case (sel)
      0: m_s = val;
      1: m_m = val;
      2: m_h = val;
      3: m_d = val;
      4: m_mo = val;
      5: m_y = (m_y / 100) * 100 + val;
      6: m_y = val * 100 + (m_y % 100);
      default: ;
    endcase
  endtask

  task automatic put(int sel, int val);
    @(negedge clk);
    field_sel = 3'(sel); digit_hi = 4'(val / 10); digit_lo = 4'(val % 10);
    load = 1'b1;
    @(negedge clk); load = 1'b0;
    model_load(sel, val);
  endtask

  task automatic set_all(int y, int mo, int d, int h, int mi, int s);
    put(6, y / 100); put(5, y % 100); put(4, mo); put(3, d);
    put(2, h); put(1, mi); put(0, s);
  endtask

  // tick until the wanted view has just come up
  task automatic align(bit want_time);
    while (view_is_time() != want_time || (pulses % 4) != 0) begin
      tick();
      check_all("R14 align");
    end
  endtask

  task automatic t_reset();
    logic [55:0] exp;
    exp = {ref_seg(2), ref_seg(0), ref_seg(0), ref_seg(0),
           ref_seg(0), ref_seg(1), ref_seg(0), ref_seg(1)};
    check_vec("R1 R12 reset date view", seg_out, exp);
    check_bit("R1 R7 reset leap", leap_year, 1'b1);
  endtask

  task automatic t_tick_hold();
    align(1'b1);
    check_all("R13 time view");
    tick(6);
    check_all("R2 held tick counts once");
    tick(1);
    check_all("R2 second tick");
  endtask

  task automatic t_time_carry();
    align(1'b1);
    put(2, 23); put(1, 59); put(0, 58);
    check_all("R9 time loaded");
    tick(); check_all("R3 59 seconds");
    tick(); check_all("R4 midnight");
    put(1, 9); put(0, 59);
    tick(); check_all("R3 minute carry");
    align(1'b0);
    check_all("R4 day advanced");
  endtask

  task automatic t_long_run();
    align(1'b1);
    put(2, 7); put(1, 0); put(0, 0);
    for (int i = 0; i < 130; i++) begin
      tick();
      check_all("R3 R14 long run");
    end
  endtask

  task automatic roll_day(string req, int y, int mo, int d);
    align(1'b0);
    set_all(y, mo, d, 23, 59, 59);
    check_all({req, " loaded"});
    tick();
    check_all(req);
  endtask

  task automatic t_months();
    roll_day("R5 30-day month", 2023, 4, 30);
    roll_day("R5 31-day month", 2023, 1, 31);
    roll_day("R5 day 30 of 31-day month", 2023, 1, 30);
    roll_day("R5 day 30 of November", 2023, 11, 30);
  endtask

  task automatic t_february();
    roll_day("R6 common February", 2023, 2, 28);
    roll_day("R6 leap February 28", 2024, 2, 28);
    roll_day("R6 leap February 29", 2024, 2, 29);
  endtask

  task automatic t_century();
    roll_day("R7 2100 not leap", 2100, 2, 28);
    roll_day("R7 1900 not leap", 1900, 2, 28);
    roll_day("R7 2400 leap", 2400, 2, 28);
    roll_day("R7 2000 leap", 2000, 2, 28);
    roll_day("R7 2036 leap", 2036, 2, 28);
  endtask

  task automatic t_year_end();
    roll_day("R8 year advance", 1999, 12, 31);
    roll_day("R8 9999 to 0000", 9999, 12, 31);
    roll_day("R7 0000 leap", 0, 2, 28);
  endtask

  task automatic t_load_fields();
    align(1'b0);
    set_all(2718, 9, 14, 11, 22, 33);
    check_all("R9 date fields");
    put(7, 42);
    check_all("R9 code 7 no change");
    align(1'b1);
    check_all("R9 time fields");
    put(7, 42);
    check_all("R9 code 7 no change time");
  endtask

  task automatic t_load_blocks_tick();
    align(1'b1);
    put(1, 10); put(2, 5);
    @(negedge clk);
    field_sel = 3'd0; digit_hi = 4'd3; digit_lo = 4'd0;
    load = 1'b1; sec_tick = 1'b1;
    @(negedge clk);
    load = 1'b0; sec_tick = 1'b0;
    @(negedge clk);
    pulses++;
    model_load(0, 30);
    check_all("R10 tick during load ignored");
    tick();
    check_all("R10 resumes from loaded value");
  endtask

  task automatic t_bad_digit();
    align(1'b1);
    @(negedge clk);
    field_sel = 3'd0; digit_hi = 4'd0; digit_lo = 4'hA; load = 1'b1;
    @(negedge clk); load = 1'b0;
    model_load(0, 0);
    check_all("R11 value above 9 shown as 0");
    put(0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_tick_hold();
    t_time_carry();
    t_long_run();
    t_months();
    t_february();
    t_century();
    t_year_end();
    t_load_fields();
    t_load_blocks_tick();
    t_bad_digit();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule